// File: doc/BRIEF.md
# Write-Back Data Cache Controller

This block is a four-way set-associative data cache together with the controller that serves word loads and stores from a processor pipeline. Each line holds two 32-bit words. Each line also keeps a tag, a valid bit per word, a dirty bit and a 2-bit age value. The number of sets is a parameter. A byte address is split as follows: bits [1:0] are ignored, bit 2 selects the word within the line, the next log2(SETS) bits select the set, and the remaining upper bits form the tag.

On a miss the controller first offers the line address to an external write-back buffer, which may still hold a recently evicted copy of the line. It goes to the memory arbiter only when the buffer misses. The memory arbiter returns a whole line in one 64-bit beat. A store miss allocates a line without fetching it. Dirty victims are handed to the write-back buffer in the same cycle that their way is reused. Every line address crossing the block edge is word 0's byte address, so its low three bits are zero.

Top module: `dcache_ctrl`

## Requirements
- R1: A load that hits returns the addressed word on cpu_rdata in the same cycle, with cpu_stall low and no memory request.
- R2: Every access marks its way most recently used. A new line goes to the lowest-indexed way whose two word-valid bits are both clear, or otherwise to the least recently used way of the set.
- R3: A load miss drives wb_lookup with the line address. If wb_hit is high, the word is taken from wb_line with no stall and no memory request. The line is installed in the cache and marked dirty, so a later eviction of it pushes it back.
- R4: A load miss that also misses the buffer stalls and raises mem_req with the line address from the next cycle until mem_ack. In the mem_ack cycle stall drops, the word is returned, and the line is installed. The word at byte offset 0 is in bits [31:0] of mem_line and the word at offset 4 is in bits [63:32].
- R5: A store to a line already present writes the word and sets the word's valid bit and the line's dirty bit, with no stall.
- R6: A store miss allocates the line without fetching and without stalling, and only the stored word is valid. A later load of the other word is a miss and is filled without losing the stored word.
- R7: When the chosen victim is valid and dirty, wb_push is high for one cycle with the victim's line address on wb_push_addr and its data on wb_push_line, word 0 in the low half.
- R8: While wb_full is high and the victim is dirty, the access stalls with wb_push and wb_lookup low. It completes in the first cycle that wb_full is low.
- R9: After reset every line is invalid, and with no access requested cpu_stall, mem_req, wb_push and wb_lookup are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_rd | input | 1 | Load request, held while stalled |
| cpu_wr | input | 1 | Store request, held while stalled |
| cpu_rdata | output | 32 | Load data, valid when cpu_rd is high and cpu_stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| wb_lookup | output | 1 | Search and claim a line in the write-back buffer |
| wb_lookup_addr | output | ADDR_W | Line address searched |
| wb_hit | input | 1 | Buffer holds the searched line |
| wb_line | input | 64 | Line returned by the buffer |
| wb_full | input | 1 | Buffer cannot take a push |
| wb_push | output | 1 | Push a dirty victim into the buffer |
| wb_push_addr | output | ADDR_W | Victim line address |
| wb_push_line | output | 64 | Victim line data |
| mem_req | output | 1 | Line read request to the memory arbiter |
| mem_addr | output | ADDR_W | Line address requested |
| mem_ack | input | 1 | Line is on mem_line this cycle |
| mem_line | input | 64 | Line returned by memory |

## Verification
Hits, buffer hits and store allocations complete in the cycle the request is presented. A memory miss stalls for one cycle, then holds mem_req until the ack cycle, so with the bench memory answering on the third request cycle the expected stall count is exactly three. State written at the end of a completing cycle is visible from the next access. Each access is therefore driven at a falling edge and sampled one nanosecond later, then repeated on following falling edges while stalled. The stall count, the returned word and the pushes that the rising edge recorded are compared against values worked out by hand from the way ordering.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    localparam int NWAYS  = 4;
    localparam int WORD_W = 32;
    localparam int LINE_W = 2 * WORD_W;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } fsm_e;
endpackage

// File: rtl/dcache_age.sv
// Recency update: touched way becomes 3, ways that were newer slide down one.
module dcache_age (
    input  logic [3:0][1:0] ages_i,
    input  logic [1:0]      touch_i,
    output logic [3:0][1:0] ages_o
);
    logic [1:0] ref_age;
    assign ref_age = ages_i[touch_i];

    for (genvar g = 0; g < 4; g++) begin : g_way
        always_comb begin
            if (touch_i == 2'(g))
                ages_o[g] = 2'd3;
            else if (ages_i[g] > ref_age)
                ages_o[g] = ages_i[g] - 2'd1;
            else
                ages_o[g] = ages_i[g];
        end
    end
endmodule

// File: rtl/dcache_lookup.sv
// Tag compare across the four ways and victim choice.
module dcache_lookup #(
    parameter int TAG_W = 27
) (
    input  logic [3:0][TAG_W-1:0] tags_i,
    input  logic [3:0][1:0]       wv_i,
    input  logic [3:0][1:0]       ages_i,
    input  logic [TAG_W-1:0]      tag_i,
    input  logic                  wsel_i,
    output logic                  match_o,
    output logic                  word_hit_o,
    output logic [1:0]            victim_o
);
    logic [3:0] hot;
    logic [3:0] empty;

    for (genvar g = 0; g < 4; g++) begin : g_cmp
        assign hot[g]   = (tags_i[g] == tag_i) && (wv_i[g] != 2'b00);
        assign empty[g] = (wv_i[g] == 2'b00);
    end

    always_comb begin
        logic [1:0] mway;
        logic [1:0] eway;
        logic [1:0] oway;
        logic       any_empty;
        mway = 2'd0;
        eway = 2'd0;
        oway = 2'd0;
        any_empty = |empty;
        for (int i = 3; i >= 0; i--) begin
            if (hot[i])             mway = 2'(i);
            if (empty[i])           eway = 2'(i);
            if (ages_i[i] == 2'd0)  oway = 2'(i);
        end
        match_o    = |hot;
        word_hit_o = |hot && wv_i[mway][wsel_i];
        if (|hot)          victim_o = mway;
        else if (any_empty) victim_o = eway;
        else               victim_o = oway;
    end
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [31:0]       cpu_rdata,
    output logic              cpu_stall,
    output logic              wb_lookup,
    output logic [ADDR_W-1:0] wb_lookup_addr,
    input  logic              wb_hit,
    input  logic [63:0]       wb_line,
    input  logic              wb_full,
    output logic              wb_push,
    output logic [ADDR_W-1:0] wb_push_addr,
    output logic [63:0]       wb_push_line,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [63:0]       mem_line
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - 3 - IDX_W;

    typedef struct packed {
        logic [TAG_W-1:0]         tag;
        logic [1:0]               wv;
        logic                     dirty;
        logic [1:0]               age;
        logic [1:0][WORD_W-1:0]   data;
    } line_t;

    typedef line_t [NWAYS-1:0] set_t;

    typedef struct packed {
        fsm_e              fsm;
        logic [1:0]        vway;
        logic [ADDR_W-1:0] maddr;
        set_t [SETS-1:0]   sets;
    } state_t;

    state_t q, d;

    logic [IDX_W-1:0]       sidx;
    logic [TAG_W-1:0]       stag;
    logic                   wsel;
    set_t                   cur;
    logic [3:0][TAG_W-1:0]  c_tag;
    logic [3:0][1:0]        c_wv;
    logic [3:0][1:0]        c_age;
    logic [3:0][1:0]        new_age;
    logic                   lk_match, lk_word_hit;
    logic [1:0]             lk_victim, touch_way;

    assign sidx = (q.fsm == ST_FILL) ? q.maddr[3 +: IDX_W] : cpu_addr[3 +: IDX_W];
    assign stag = (q.fsm == ST_FILL) ? q.maddr[ADDR_W-1 -: TAG_W] : cpu_addr[ADDR_W-1 -: TAG_W];
    assign wsel = cpu_addr[2];
    assign cur  = q.sets[sidx];

    for (genvar g = 0; g < NWAYS; g++) begin : g_unpack
        assign c_tag[g] = cur[g].tag;
        assign c_wv[g]  = cur[g].wv;
        assign c_age[g] = cur[g].age;
    end

    dcache_lookup #(.TAG_W(TAG_W)) u_lookup (
        .tags_i     (c_tag),
        .wv_i       (c_wv),
        .ages_i     (c_age),
        .tag_i      (stag),
        .wsel_i     (wsel),
        .match_o    (lk_match),
        .word_hit_o (lk_word_hit),
        .victim_o   (lk_victim)
    );

    assign touch_way = (q.fsm == ST_FILL) ? q.vway : lk_victim;

    dcache_age u_age (
        .ages_i  (c_age),
        .touch_i (touch_way),
        .ages_o  (new_age)
    );

    always_comb begin
        line_t       vl;
        line_t       nl;
        logic        need_push;
        logic        fill;
        logic        from_buf;
        logic        touch;
        logic [1:0]  fway;
        logic [63:0] fetched;

        d         = q;
        cpu_rdata = '0;
        cpu_stall = 1'b0;
        wb_lookup = 1'b0;
        wb_push   = 1'b0;
        mem_req   = 1'b0;
        mem_addr  = q.maddr;
        wb_lookup_addr = {cpu_addr[ADDR_W-1:3], 3'b000};

        vl           = cur[lk_victim];
        wb_push_addr = {vl.tag, sidx, 3'b000};
        wb_push_line = vl.data;
        need_push    = !lk_match && vl.dirty && (vl.wv != 2'b00);

        fill     = 1'b0;
        from_buf = 1'b0;
        touch    = 1'b0;
        fway     = lk_victim;
        fetched  = '0;

        case (q.fsm)
            ST_IDLE: begin
                if (cpu_rd) begin
                    if (lk_word_hit) begin
                        cpu_rdata = vl.data[wsel];
                        touch     = 1'b1;
                    end else if (need_push && wb_full) begin
                        cpu_stall = 1'b1;
                    end else begin
                        wb_lookup = 1'b1;
                        wb_push   = need_push;
                        if (wb_hit) begin
                            cpu_rdata = wsel ? wb_line[63:32] : wb_line[31:0];
                            fill      = 1'b1;
                            from_buf  = 1'b1;
                            fetched   = wb_line;
                        end else begin
                            cpu_stall = 1'b1;
                            d.fsm     = ST_FILL;
                            d.vway    = lk_victim;
                            d.maddr   = {cpu_addr[ADDR_W-1:3], 3'b000};
                            if (!lk_match) begin
                                d.sets[sidx][lk_victim].wv    = 2'b00;
                                d.sets[sidx][lk_victim].dirty = 1'b0;
                            end
                        end
                    end
                end else if (cpu_wr) begin
                    if (lk_match) begin
                        d.sets[sidx][lk_victim].data[wsel] = cpu_wdata;
                        d.sets[sidx][lk_victim].wv[wsel]   = 1'b1;
                        d.sets[sidx][lk_victim].dirty      = 1'b1;
                        touch = 1'b1;
                    end else if (need_push && wb_full) begin
                        cpu_stall = 1'b1;
                    end else begin
                        wb_push  = need_push;
                        nl       = vl;
                        nl.tag   = stag;
                        nl.wv    = wsel ? 2'b10 : 2'b01;
                        nl.dirty = 1'b1;
                        nl.data  = '0;
                        nl.data[wsel] = cpu_wdata;
                        d.sets[sidx][lk_victim] = nl;
                        touch = 1'b1;
                    end
                end
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                cpu_stall = !mem_ack;
                if (mem_ack) begin
                    cpu_rdata = wsel ? mem_line[63:32] : mem_line[31:0];
                    fill      = 1'b1;
                    fetched   = mem_line;
                    fway      = q.vway;
                    d.fsm     = ST_IDLE;
                end
            end
            default: d.fsm = ST_IDLE;
        endcase

        if (fill) begin
            nl = cur[fway];
            if (q.fsm == ST_IDLE && !lk_match) begin
                nl.wv    = 2'b00;
                nl.dirty = 1'b0;
            end
            for (int w = 0; w < 2; w++) begin
                if (!nl.wv[w]) nl.data[w] = fetched[32*w +: 32];
            end
            nl.wv    = 2'b11;
            nl.tag   = stag;
            nl.dirty = nl.dirty | from_buf;
            d.sets[sidx][fway] = nl;
            touch = 1'b1;
        end

        if (touch) begin
            for (int i = 0; i < NWAYS; i++) d.sets[sidx][i].age = new_age[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.fsm   <= ST_IDLE;
            q.vway  <= '0;
            q.maddr <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int i = 0; i < NWAYS; i++) begin
                    q.sets[s][i]     <= '0;
                    q.sets[s][i].age <= 2'(i);
                end
            end
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic              cpu_stall,
    input logic              wb_lookup,
    input logic              wb_push,
    input logic              wb_full,
    input logic [ADDR_W-1:0] wb_push_addr,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);
    // R4
    fill_wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |-> cpu_stall);

    // R4
    fill_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4
    fill_addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R8
    push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |-> !wb_full);

    // R7
    push_line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |-> ((wb_push_addr[2:0] == 3'b000) && (cpu_rd || cpu_wr)));

    // R6
    store_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> (!wb_lookup && !mem_req));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_rd || cpu_wr) |-> (!cpu_stall && !wb_push && !wb_lookup && !mem_req));
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dcache_ctrl_test.sv
`timescale 1ns/1ps
module dcache_ctrl_test;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [31:0]   cpu_wdata = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [31:0]   cpu_rdata;
    logic          cpu_stall;
    logic          wb_lookup;
    logic [AW-1:0] wb_lookup_addr;
    logic          wb_hit;
    logic [63:0]   wb_line;
    logic          wb_full;
    logic          wb_push;
    logic [AW-1:0] wb_push_addr;
    logic [63:0]   wb_push_line;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_ack;
    logic [63:0]   mem_line;

    always #4 clk = ~clk;

    dcache_ctrl #(.ADDR_W(AW), .SETS(4)) uut (.*);

    function automatic logic [31:0] adr(int t, int s, int w);
        return 32'((t << 5) | (s << 3) | (w << 2));
    endfunction

    function automatic logic [31:0] memw(logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    // memory model: answers on the third request cycle
    logic [1:0] mcnt;
    assign mem_line = {memw(mem_addr + 32'd4), memw(mem_addr)};
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= '0; mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mcnt <= mcnt + 2'd1; mem_ack <= (mcnt == 2'd1);
        end else begin
            mcnt <= '0; mem_ack <= 1'b0;
        end
    end

    // write-back buffer model: four entries, claimed on lookup hit
    logic          bv [4];
    logic [AW-1:0] ba [4];
    logic [63:0]   bl [4];
    logic          force_full = 1'b0;
    int            hit_i, free_i;
    int            push_cnt;
    logic [AW-1:0] last_paddr;
    logic [63:0]   last_pline;

    always_comb begin
        hit_i = -1; free_i = -1;
        for (int i = 3; i >= 0; i--) begin
            if (bv[i] && ba[i] == wb_lookup_addr) hit_i = i;
            if (!bv[i]) free_i = i;
        end
        wb_hit  = wb_lookup && (hit_i >= 0);
        wb_line = (hit_i >= 0) ? bl[hit_i[1:0]] : 64'd0;
        wb_full = force_full || (free_i < 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                bv[i] <= 1'b0; ba[i] <= '0; bl[i] <= '0;
            end
            push_cnt <= 0; last_paddr <= '0; last_pline <= '0;
        end else begin
            if (wb_hit) bv[hit_i[1:0]] <= 1'b0;
            if (wb_push) begin
                if (free_i >= 0) begin
                    bv[free_i[1:0]] <= 1'b1;
                    ba[free_i[1:0]] <= wb_push_addr;
                    bl[free_i[1:0]] <= wb_push_line;
                end
                push_cnt   <= push_cnt + 1;
                last_paddr <= wb_push_addr;
                last_pline <= wb_push_line;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [3:0]  stalls;
        logic        push;
        logic [31:0] paddr;
        logic [63:0] pline;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        // R4 cold miss to memory
        '{1'b0, adr(1,0,0), 32'd0,   memw(adr(1,0,0)), 4'd3, 1'b0, 32'd0, 64'd0, 4'd4},
        // R1 hit on odd word, upper half of fill
        '{1'b0, adr(1,0,1), 32'd0,   memw(adr(1,0,1)), 4'd0, 1'b0, 32'd0, 64'd0, 4'd1},
        // R5 store hit
        '{1'b1, adr(1,0,0), 32'd111, 32'd0,            4'd0, 1'b0, 32'd0, 64'd0, 4'd5},
        // R5 read back stored word
        '{1'b0, adr(1,0,0), 32'd0,   32'd111,          4'd0, 1'b0, 32'd0, 64'd0, 4'd5},
        // R6 store miss allocates without fetch (way 1)
        '{1'b1, adr(2,0,1), 32'd222, 32'd0,            4'd0, 1'b0, 32'd0, 64'd0, 4'd6},
        // R6 stored word readable
        '{1'b0, adr(2,0,1), 32'd0,   32'd222,          4'd0, 1'b0, 32'd0, 64'd0, 4'd6},
        // R6 other word invalid: fetched
        '{1'b0, adr(2,0,0), 32'd0,   memw(adr(2,0,0)), 4'd3, 1'b0, 32'd0, 64'd0, 4'd6},
        // R6 stored word kept by merge
        '{1'b0, adr(2,0,1), 32'd0,   32'd222,          4'd0, 1'b0, 32'd0, 64'd0, 4'd6},
        // R2 lowest empty way 2
        '{1'b0, adr(3,0,0), 32'd0,   memw(adr(3,0,0)), 4'd3, 1'b0, 32'd0, 64'd0, 4'd2},
        // R2 lowest empty way 3
        '{1'b0, adr(4,0,0), 32'd0,   memw(adr(4,0,0)), 4'd3, 1'b0, 32'd0, 64'd0, 4'd2},
        // R2 touch way 0 so way 1 becomes oldest
        '{1'b0, adr(1,0,1), 32'd0,   memw(adr(1,0,1)), 4'd0, 1'b0, 32'd0, 64'd0, 4'd2},
        // R7 dirty oldest way 1 pushed, then memory fill
        '{1'b0, adr(5,0,0), 32'd0,   memw(adr(5,0,0)), 4'd3, 1'b1, adr(2,0,0),
          {32'd222, memw(adr(2,0,0))}, 4'd7},
        // R3 line found in buffer, no stall
        '{1'b0, adr(2,0,1), 32'd0,   32'd222,          4'd0, 1'b0, 32'd0, 64'd0, 4'd3},
        // R3 other word came with the buffer line
        '{1'b0, adr(2,0,0), 32'd0,   memw(adr(2,0,0)), 4'd0, 1'b0, 32'd0, 64'd0, 4'd3},
        // R6 store miss, clean victim way 3
        '{1'b1, adr(6,0,1), 32'd333, 32'd0,            4'd0, 1'b0, 32'd0, 64'd0, 4'd6},
        // R7 store miss evicts dirty way 0
        '{1'b1, adr(7,0,0), 32'd444, 32'd0,            4'd0, 1'b1, adr(1,0,0),
          {memw(adr(1,0,1)), 32'd111}, 4'd7},
        // R3 evicted line recovered from buffer
        '{1'b0, adr(1,0,1), 32'd0,   memw(adr(1,0,1)), 4'd0, 1'b0, 32'd0, 64'd0, 4'd3},
        // R4 separate set misses independently
        '{1'b0, adr(1,1,0), 32'd0,   memw(adr(1,1,0)), 4'd3, 1'b0, 32'd0, 64'd0, 4'd4}
    };

    task automatic run_op(bit wr, logic [31:0] addr, logic [31:0] data,
                          output logic [31:0] got, output int stalls);
        @(negedge clk);
        cpu_addr = addr; cpu_wdata = data; cpu_rd = !wr; cpu_wr = wr;
        stalls = 0; got = '0;
        forever begin
            #1;
            if (!cpu_stall) begin got = cpu_rdata; break; end
            stalls++;
            if (stalls > 30) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "ALL", "watchdog expired", 64'd0, 64'd1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] got;
        int          st;
        int          p0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9 quiet after reset
        chk(!cpu_stall, "R9", "stall after reset", 64'(cpu_stall), 64'd0);
        chk(!mem_req && !wb_push && !wb_lookup, "R9", "requests after reset",
            {61'd0, mem_req, wb_push, wb_lookup}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string rq;
            v  = VEC[i];
            rq = $sformatf("R%0d", v.req);
            p0 = push_cnt;
            run_op(v.wr, v.addr, v.wdata, got, st);
            chk(st == int'(v.stalls), rq, $sformatf("stall cycles step %0d", i),
                64'(st), 64'(v.stalls));
            if (!v.wr)
                chk(got == v.exp, rq, $sformatf("load data step %0d", i), 64'(got), 64'(v.exp));
            chk((push_cnt - p0) == int'(v.push), rq, $sformatf("push count step %0d", i),
                64'(push_cnt - p0), 64'(v.push));
            if (v.push) begin
                chk(last_paddr == v.paddr, rq, $sformatf("push addr step %0d", i),
                    64'(last_paddr), 64'(v.paddr));
                chk(last_pline == v.pline, rq, $sformatf("push line step %0d", i),
                    last_pline, v.pline);
            end
        end

        // R8 buffer full blocks a dirty eviction (victim way 2, line of tag 2)
        force_full = 1'b1;
        p0 = push_cnt;
        @(negedge clk);
        cpu_addr = adr(8,0,0); cpu_wdata = 32'd555; cpu_wr = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(cpu_stall, "R8", "stall while full", 64'(cpu_stall), 64'd1);
            chk(!wb_push && !wb_lookup, "R8", "no push while full",
                {62'd0, wb_push, wb_lookup}, 64'd0);
            @(negedge clk);
        end
        force_full = 1'b0;
        #1;
        chk(!cpu_stall && wb_push, "R8", "completes when not full",
            {62'd0, cpu_stall, wb_push}, 64'd1);
        @(posedge clk);
        #1;
        cpu_wr = 1'b0;
        chk(push_cnt - p0 == 1, "R7", "single push after release", 64'(push_cnt - p0), 64'd1);
        chk(last_paddr == adr(2,0,0), "R7", "push addr after release",
            64'(last_paddr), 64'(adr(2,0,0)));
        chk(last_pline == {32'd222, memw(adr(2,0,0))}, "R3", "buffer-filled line was dirty",
            last_pline, {32'd222, memw(adr(2,0,0))});

        run_op(1'b0, adr(8,0,0), 32'd0, got, st);
        chk(got == 32'd555 && st == 0, "R5", "read after released store",
            {got, 32'(st)}, {32'd555, 32'd0});

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule